// File: doc/BRIEF.md
# Two-Way Word Rotator

This block turns an n-bit word end over end by a chosen number of places, in either direction, within one combinational path. The word width is a power of two, so the place count fits in log2(n) bits and every count from zero to n-1 is meaningful. It suits an execution unit or a data-alignment path that needs rotation without a clock of latency.

The datapath is a chain of log2(n) fixed-distance stages. The stage with index i either turns the word left by 2^i places or passes it through, and it is steered by bit i of the place count. A right turn does not have a chain of its own and has no subtractor. A single left-by-one stage sits at the front of the chain, and the inverted count drives the rest. This works because turning right by a equals turning left by (n - a) mod n, which equals ~a + 1 on log2(n) bits.

Top module: `bidir_rotator`

## Requirements
- R1: With `dir_right` = 0, output bit j equals `din[(j - amt) mod WIDTH]` for every j; for example, with WIDTH = 8, 8'b00000010 turned left by 1 gives 8'b00000100 and turned left by 3 gives 8'b00010000.
- R2: With `dir_right` = 1, output bit j equals `din[(j + amt) mod WIDTH]` for every j.
- R3: With `amt` = 0, `dout` equals `din` whichever direction is selected.
- R4: The block holds no state: `dout` reflects the present inputs with no clock edge in between.
- R5: The number of 1 bits in `dout` always equals the number in `din`.
- R6: A right turn by a gives the same word as a left turn by (WIDTH - a) mod WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | WIDTH | Word to rotate |
| amt | input | AMT_W = log2(WIDTH) | Number of places to rotate |
| dir_right | input | 1 | 0 rotates toward the MSB (left), 1 rotates toward the LSB (right) |
| dout | output | WIDTH | Rotated word |

## Verification
The hardest path to reach is a right turn whose inverted count has all bits set, which happens when the count is zero. In that case the front stage and every chain stage fire together, and the total movement has to wrap to exactly one full turn. Distinct bit patterns expose a wrong wrap, but words such as all-zeros or all-ones hide it. The stimulus therefore sweeps every count in both directions with a one-hot marker and a lopsided pattern. It also adds seeded random words, so each wrap distance is exercised with data that shows whether bits landed in the wrong place.

// File: rtl/rot_pkg.sv
package rot_pkg;
  typedef enum logic {
    ROT_LEFT  = 1'b0,
    ROT_RIGHT = 1'b1
  } rot_dir_e;
endpackage

// File: rtl/rot_stage.sv
module rot_stage #(
  parameter int WIDTH = 8,
  parameter int DIST  = 1
) (
  input  logic             en,
  input  logic [WIDTH-1:0] x,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    if (en) y = {x[WIDTH-1-DIST:0], x[WIDTH-1:WIDTH-DIST]};
    else    y = x;
    // a rotation never creates or destroys ones
    p_stage_ones_kept_r5: assert ($countones(y) == $countones(x))
      else $error("stage changed population");
  end
endmodule

// File: rtl/rot_amount_xform.sv
module rot_amount_xform
  import rot_pkg::*;
#(
  parameter int AMT_W = 3
) (
  input  logic [AMT_W-1:0] amt,
  input  rot_dir_e         dir,
  output logic             pre_en,
  output logic [AMT_W-1:0] eff_amt
);
  always_comb begin
    pre_en  = (dir == ROT_RIGHT);
    eff_amt = pre_en ? ~amt : amt;
  end

  // right turn: one front place plus eff_amt must cancel amt modulo 2^AMT_W
  logic [AMT_W-1:0] wrap_sum;
  always_comb begin
    wrap_sum = eff_amt + AMT_W'(pre_en) + amt;
    if (dir == ROT_RIGHT)
      p_right_wraps_r6: assert (wrap_sum == '0)
        else $error("right amount does not wrap");
  end
endmodule

// File: rtl/rot_chain.sv
module rot_chain #(
  parameter int WIDTH = 8,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input  logic [AMT_W-1:0] sel,
  input  logic [WIDTH-1:0] x,
  output logic [WIDTH-1:0] y
);
  logic [WIDTH-1:0] lvl [AMT_W+1];

  assign lvl[0] = x;

  for (genvar i = 0; i < AMT_W; i++) begin : g_stage
    rot_stage #(.WIDTH(WIDTH), .DIST(1 << i)) u_stage (
      .en (sel[i]),
      .x  (lvl[i]),
      .y  (lvl[i+1])
    );
  end

  assign y = lvl[AMT_W];
endmodule

// File: rtl/bidir_rotator.sv
module bidir_rotator
  import rot_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [AMT_W-1:0] amt,
  input  logic             dir_right,
  output logic [WIDTH-1:0] dout
);
  rot_dir_e         dir;
  logic             pre_en;
  logic [AMT_W-1:0] eff_amt;
  logic [WIDTH-1:0] pre_word;

  assign dir = rot_dir_e'(dir_right);

  rot_amount_xform #(.AMT_W(AMT_W)) u_xform (
    .amt     (amt),
    .dir     (dir),
    .pre_en  (pre_en),
    .eff_amt (eff_amt)
  );

  rot_stage #(.WIDTH(WIDTH), .DIST(1)) u_front (
    .en (pre_en),
    .x  (din),
    .y  (pre_word)
  );

  rot_chain #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_chain (
    .sel (eff_amt),
    .x   (pre_word),
    .y   (dout)
  );

  // end-to-end checks at the ports
  int unsigned src_idx;
  always_comb begin
    if (dir_right) src_idx = (int'(amt)) % WIDTH;
    else           src_idx = (WIDTH - int'(amt)) % WIDTH;
    if (amt == '0)
      p_zero_identity_r3: assert (dout == din) else $error("zero amount moved data");
    if (!dir_right)
      p_left_bit0_r1: assert (dout[0] == din[src_idx]) else $error("left bit0 wrong");
    else
      p_right_bit0_r2: assert (dout[0] == din[src_idx]) else $error("right bit0 wrong");
    p_ones_kept_r5: assert ($countones(dout) == $countones(din))
      else $error("population changed");
  end
endmodule

// File: tb/tb_bidir_rotator.sv
module tb_bidir_rotator;
  localparam int WIDTH = 8;
  localparam int AMT_W = $clog2(WIDTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [WIDTH-1:0] din;
  logic [AMT_W-1:0] amt;
  logic             dir_right;
  logic [WIDTH-1:0] dout;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  bidir_rotator #(.WIDTH(WIDTH), .AMT_W(AMT_W)) dut (
    .din(din), .amt(amt), .dir_right(dir_right), .dout(dout)
  );

  function automatic logic [WIDTH-1:0] ref_rot(logic [WIDTH-1:0] x, int a, bit right);
    logic [WIDTH-1:0] r;
    for (int j = 0; j < WIDTH; j++)
      r[j] = right ? x[(j + a) % WIDTH] : x[(j - a + WIDTH) % WIDTH];
    return r;
  endfunction

  function automatic int ones(logic [WIDTH-1:0] x);
    int c = 0;
    for (int j = 0; j < WIDTH; j++) c += int'(x[j]);
    return c;
  endfunction

  task automatic check(string req, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: din=%b amt=%0d right=%0b got %b expected %b",
               req, din, amt, dir_right, act, exp);
    end
  endtask

  // drive then sample 1 ns later, well away from the clock edge
  task automatic apply(logic [WIDTH-1:0] d, int a, bit r);
    @(negedge clk);
    din = d; amt = AMT_W'(a); dir_right = r;
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      misses++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    din = '0; amt = '0; dir_right = 1'b0;
    #20 rst_n = 1'b1;

    // all-zero inputs give all-zero output (R3)
    apply('0, 0, 0);
    check("R3 idle", dout, '0);

    // directed examples (R1)
    apply(8'b0000_0010, 1, 0); check("R1 left1", dout, 8'b0000_0100);
    apply(8'b0000_0010, 3, 0); check("R1 left3", dout, 8'b0001_0000);
    // right wrap corners (R2)
    apply(8'b0000_0001, 1, 1); check("R2 wrap", dout, 8'b1000_0000);
    apply(8'b1000_0000, 7, 1); check("R2 far", dout, 8'b0000_0001);
    // zero amount in both directions (R3)
    apply(8'hA7, 0, 1); check("R3 right0", dout, 8'hA7);
    apply(8'hA7, 0, 0); check("R3 left0", dout, 8'hA7);

    // R4: output follows a change with no clock edge between
    @(negedge clk);
    din = 8'h01; amt = 3'd2; dir_right = 1'b0; #1;
    check("R4 first", dout, 8'h04);
    amt = 3'd5; #1;
    check("R4 no edge", dout, 8'h20);

    // exhaustive sweep of amounts and directions with a one-hot and a lopsided word
    for (int d = 0; d < 2; d++)
      for (int a = 0; a < WIDTH; a++)
        for (int b = 0; b < WIDTH; b++) begin
          logic [WIDTH-1:0] w;
          w = (8'b1 << b) | 8'b0000_0110;
          apply(w, a, d[0]);
          check(d[0] ? "R2 sweep" : "R1 sweep", dout, ref_rot(w, a, d[0]));
          check("R5 ones", WIDTH'(ones(dout)), WIDTH'(ones(w)));
        end

    // R6: right by a equals left by (W - a) mod W
    for (int a = 0; a < WIDTH; a++) begin
      logic [WIDTH-1:0] w, rres;
      w = WIDTH'($urandom);
      apply(w, a, 1); rres = dout;
      apply(w, (WIDTH - a) % WIDTH, 0);
      check("R6 equiv", rres, dout);
    end

    // seeded random mix
    for (int n = 0; n < 300; n++) begin
      logic [WIDTH-1:0] w;
      int a;
      bit r;
      w = WIDTH'($urandom);
      a = int'($urandom % WIDTH);
      r = bit'($urandom % 2);
      apply(w, a, r);
      check(r ? "R2 random" : "R1 random", dout, ref_rot(w, a, r));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule